// File: doc/BRIEF.md
# Stream Reservation Bandwidth Calculator

This block admits one new reserved stream at a time into one of two shaped transmit queues. Queue A carries the higher-rate class and queue B the lower-rate class. A request gives the class, the frame size in bytes and the current link-rate constant. The block first checks the request. It then works out how much idle slope the stream needs and adds that amount to the queue's running total. Last, it computes the high-credit limit for that queue. The new total and the high credit are published together with a one-cycle done pulse.

All arithmetic that divides goes through a single restoring divider, which produces one quotient bit per clock. Every admitted request therefore takes the same number of cycles. A rejected request is answered on the next cycle, and the stored totals stay as they were. The block accepts no new request until the current one has finished.

Top module: `srbw_calc`

## Requirements
- R1: A request whose frame size is below 64 or above 1522 is rejected. The rejection shows as `done` and `err` high together in the cycle after the accepting edge, and the running totals and the recorded class-A frame size keep their values.
- R2: The base increment is floor(frame × link_rate × 16 / 1,000,000). A class-B request (class code 1) adds the base increment to the class-B total, modulo 2^32, and publishes the new total on `upd_slope` with `upd_queue` = 1.
- R3: A class-A request (class code 0) adds twice the base increment to the class-A total, modulo 2^32, and publishes the new total on `upd_slope` with `upd_queue` = 0.
- R4: The class-A high credit is (2^31 + floor(new class-A total × 1522 / link_rate)) mod 2^32.
- R5: The class-B high credit is 2^31 OR'ed with the low 32 bits of floor(new class-B total × (1522 + last class-A frame size) / (link_rate − class-A total)).
- R6: An admitted class-A request records its frame size as the last class-A frame size. Later class-B high credits use that recorded size.
- R7: Class codes 2 and 3 are rejected in the same way as in R1.
- R8: After reset, both totals, the recorded frame size and the published outputs are zero, `req_ready` is high and `done` is low.
- R9: An admitted request raises `done` with `err` low on the 98th rising edge after the accepting edge (2 × 48 + 2 with the default widths). `req_ready` is low from the cycle after acceptance until `done` rises. A request presented while `req_ready` is low has no effect.
- R10: A request whose divisor is not positive is rejected as in R1. For class A the divisor is `link_rate`, so it must be non-zero. For class B the divisor is `link_rate` minus the class-A total.
- R11: `upd_queue`, `upd_slope` and `upd_hicred` change only in a cycle where `done` is high with `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_class | input | 2 | 0 = class A, 1 = class B, 2 and 3 invalid |
| req_frame | input | 16 | Frame size in bytes |
| link_rate | input | 16 | Link-rate constant, sampled on acceptance |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected; valid while `done` is high |
| upd_queue | output | 1 | Queue that was updated (0 = A, 1 = B) |
| upd_slope | output | 32 | New idle-slope total of that queue |
| upd_hicred | output | 32 | New high-credit value of that queue |

## Verification
The stimulus mixes several class sequences. Class-A admissions of different sizes confirm the doubling. Class-B admissions placed before and after class-A activity show that the recorded class-A size and the remaining link rate feed into the class-B credit. Changing the link-rate constant between requests exposes any stale capture of the rate. Frame sizes 63, 64, 1522 and 1523 pin down where the range check sits. A rejected request followed by a valid one shows that the rejection left the totals alone. A non-positive divisor in each class, and a request poked in while the block is busy, separate the rejection and refusal paths from the arithmetic.

// File: rtl/srbw_pkg.sv
package srbw_pkg;
  localparam int unsigned FRAME_MIN  = 64;
  localparam int unsigned FRAME_MAX  = 1522;
  localparam int unsigned RATE_SCALE = 16;
  localparam int unsigned MEGA       = 1000000;

  localparam logic [1:0] CLS_A = 2'd0;
  localparam logic [1:0] CLS_B = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INC  = 2'd1,
    ST_CRED = 2'd2
  } calc_state_t;
endpackage

// File: rtl/srbw_admit_check.sv
module srbw_admit_check
  import srbw_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int RATE_W  = 16,
  parameter int SLOPE_W = 32
) (
  input  logic [1:0]         cls,
  input  logic [FRAME_W-1:0] frame,
  input  logic [RATE_W-1:0]  rate,
  input  logic [SLOPE_W-1:0] slope_a,
  output logic               ok
);
  localparam int CW = ((RATE_W > SLOPE_W) ? RATE_W : SLOPE_W) + 1;

  logic size_ok, cls_ok, room_ok;

  always_comb begin
    size_ok = (frame >= FRAME_W'(FRAME_MIN)) && (frame <= FRAME_W'(FRAME_MAX));
    cls_ok  = (cls == CLS_A) || (cls == CLS_B);
    if (cls == CLS_B) room_ok = CW'(rate) > CW'(slope_a);
    else              room_ok = (rate != '0);
    ok = size_ok && cls_ok && room_ok;
  end
endmodule

// File: rtl/srbw_restoring_div.sv
module srbw_restoring_div #(
  parameter int NW = 48,
  parameter int DW = 32,
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quot
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [DW-1:0]    rem_q;
  logic [DW-1:0]    den_q;
  logic [NW-1:0]    quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW:0]      shifted;
  logic             fits;

  assign busy = (cnt_q != '0);
  assign quot = quo_q[QW-1:0];

  always_comb begin
    shifted = {rem_q, quo_q[NW-1]};
    fits    = shifted >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem_q <= '0;
        den_q <= den;
        quo_q <= num;
        cnt_q <= CNT_W'(NW);
      end else if (busy) begin
        rem_q <= fits ? DW'(shifted - {1'b0, den_q}) : shifted[DW-1:0];
        quo_q <= {quo_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  // R9
  div_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9
  div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/srbw_calc.sv
module srbw_calc
  import srbw_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int RATE_W  = 16,
  parameter int SLOPE_W = 32,
  parameter int NUM_W   = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_class,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic [RATE_W-1:0]  link_rate,
  output logic               done,
  output logic               err,
  output logic               upd_queue,
  output logic [SLOPE_W-1:0] upd_slope,
  output logic [SLOPE_W-1:0] upd_hicred
);
  localparam logic [SLOPE_W-1:0] ZERO_CREDIT = SLOPE_W'(1) << (SLOPE_W - 1);

  calc_state_t        state;
  logic               is_b;
  logic [FRAME_W-1:0] frame_q;
  logic [RATE_W-1:0]  rate_q;
  logic [SLOPE_W-1:0] tot_a, tot_b, slope_q;
  logic [FRAME_W-1:0] last_a;

  logic               accept, ok;
  logic               div_start, div_busy, div_done;
  logic [NUM_W-1:0]   div_num;
  logic [SLOPE_W-1:0] div_den, div_quot;
  logic [SLOPE_W-1:0] slope_new, hic_new;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  srbw_admit_check #(
    .FRAME_W(FRAME_W), .RATE_W(RATE_W), .SLOPE_W(SLOPE_W)
  ) u_check (
    .cls(req_class), .frame(req_frame), .rate(link_rate),
    .slope_a(tot_a), .ok(ok)
  );

  srbw_restoring_div #(
    .NW(NUM_W), .DW(SLOPE_W), .QW(SLOPE_W)
  ) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  always_comb begin
    slope_new = is_b ? (tot_b + div_quot) : (tot_a + (div_quot << 1));
    hic_new   = is_b ? (ZERO_CREDIT | div_quot) : (ZERO_CREDIT + div_quot);
    div_start = 1'b0;
    div_num   = '0;
    div_den   = '0;
    case (state)
      ST_IDLE: begin
        div_start = accept && ok;
        div_num   = NUM_W'(req_frame) * NUM_W'(link_rate) * NUM_W'(RATE_SCALE);
        div_den   = SLOPE_W'(MEGA);
      end
      ST_INC: begin
        div_start = div_done;
        if (is_b) begin
          div_num = NUM_W'(slope_new) * (NUM_W'(FRAME_MAX) + NUM_W'(last_a));
          div_den = SLOPE_W'(rate_q) - tot_a;
        end else begin
          div_num = NUM_W'(slope_new) * NUM_W'(FRAME_MAX);
          div_den = SLOPE_W'(rate_q);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      is_b       <= 1'b0;
      frame_q    <= '0;
      rate_q     <= '0;
      tot_a      <= '0;
      tot_b      <= '0;
      last_a     <= '0;
      slope_q    <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      upd_queue  <= 1'b0;
      upd_slope  <= '0;
      upd_hicred <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (ok) begin
            state   <= ST_INC;
            is_b    <= (req_class == CLS_B);
            frame_q <= req_frame;
            rate_q  <= link_rate;
          end else begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        ST_INC: if (div_done) begin
          slope_q <= slope_new;
          state   <= ST_CRED;
        end
        ST_CRED: if (div_done) begin
          state      <= ST_IDLE;
          done       <= 1'b1;
          upd_queue  <= is_b;
          upd_slope  <= slope_q;
          upd_hicred <= hic_new;
          if (is_b) tot_b <= slope_q;
          else begin
            tot_a  <= slope_q;
            last_a <= frame_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  bad_frame_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && ((req_frame < FRAME_W'(FRAME_MIN)) || (req_frame > FRAME_W'(FRAME_MAX))))
      |=> (done && err));

  // R7
  bad_class_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (req_class > CLS_B)) |=> (done && err));

  // R10
  no_room_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (req_class == CLS_B) && ((SLOPE_W + 1)'(link_rate) <= (SLOPE_W + 1)'(tot_a)))
      |=> (done && err));

  // R1
  rej_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> ($stable(tot_a) && $stable(tot_b) && $stable(last_a)));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !req_ready);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && !err) |-> ($stable(upd_slope) && $stable(upd_hicred) && $stable(upd_queue)));
endmodule

// File: tb/tb_srbw_calc.sv
`timescale 1ns/1ps
module tb_srbw_calc;
  localparam int NW      = 48;
  localparam int LAT_OK  = 2 * NW + 3;
  localparam longint M32 = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_class = 2'd0;
  logic [15:0] req_frame = 16'd0;
  logic [15:0] link_rate = 16'h7735;
  logic        done, err, upd_queue;
  logic [31:0] upd_slope, upd_hicred;

  always #5 clk = ~clk;

  srbw_calc dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_frame(req_frame), .link_rate(link_rate),
    .done(done), .err(err), .upd_queue(upd_queue),
    .upd_slope(upd_slope), .upd_hicred(upd_hicred)
  );

  int tests = 0;
  int fails = 0;

  // behavioural model state
  longint m_tot_a = 0, m_tot_b = 0, m_last_a = 0;
  longint mo_slope = 0, mo_hic = 0;
  bit     mo_q = 0;
  bit     active = 0;
  int     k_since = 0, exp_lat = 0;
  bit     exp_err = 0, exp_q = 0;
  longint exp_slope = 0, exp_hic = 0;
  string  tag = "R8";

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (active) begin
        k_since++;
        if (k_since == exp_lat) begin
          chk(done == 1'b1, tag, "done", done, 1);
          chk(err == exp_err, tag, "err", err, exp_err);
          chk(req_ready == 1'b1, "R9", "ready at done", req_ready, 1);
          if (!exp_err) begin
            mo_slope = exp_slope;
            mo_hic   = exp_hic;
            mo_q     = exp_q;
          end
          active = 0;
        end else begin
          chk(done == 1'b0, "R9", "early done", done, 0);
          chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
        end
      end else begin
        chk(done == 1'b0, "R9", "spurious done", done, 0);
        chk(req_ready == 1'b1, "R9", "ready idle", req_ready, 1);
      end
      chk(upd_slope == 32'(mo_slope), tag, "upd_slope", upd_slope, mo_slope);
      chk(upd_hicred == 32'(mo_hic), tag, "upd_hicred", upd_hicred, mo_hic);
      chk(upd_queue == mo_q, "R11", "upd_queue", upd_queue, mo_q);
    end
  end

  task automatic request(input logic [1:0] cls, input int frame, input int rate,
                         input string t, input bit poke);
    longint base, ns, den;
    @(negedge clk);
    req_valid = 1'b1;
    req_class = cls;
    req_frame = 16'(frame);
    link_rate = 16'(rate);
    @(posedge clk);
    tag     = t;
    exp_err = 0;
    base    = (longint'(frame) * rate * 16) / 1000000;
    if (frame < 64 || frame > 1522 || cls > 2'd1) exp_err = 1;
    else if (cls == 2'd0 && rate == 0) exp_err = 1;
    else if (cls == 2'd1 && longint'(rate) <= m_tot_a) exp_err = 1;
    if (exp_err) exp_lat = 1;
    else begin
      exp_lat = LAT_OK;
      if (cls == 2'd0) begin
        ns        = (m_tot_a + 2 * base) & M32;
        exp_hic   = (64'h8000_0000 + (ns * 1522) / rate) & M32;
        m_tot_a   = ns;
        m_last_a  = frame;
        exp_q     = 0;
      end else begin
        ns        = (m_tot_b + base) & M32;
        den       = rate - m_tot_a;
        exp_hic   = 64'h8000_0000 | (((ns * (1522 + m_last_a)) / den) & M32);
        m_tot_b   = ns;
        exp_q     = 1;
      end
      exp_slope = ns;
    end
    k_since = 0;
    active  = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      // R9: request while busy must be ignored
      req_valid = 1'b1;
      req_class = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (exp_lat - 6) @(negedge clk);
    end else begin
      repeat (exp_lat) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    chk(req_ready == 1'b1, "R8", "ready after reset", req_ready, 1);
    chk(done == 1'b0 && err == 1'b0, "R8", "done/err after reset", done, 0);
    chk(upd_slope == 0 && upd_hicred == 0, "R8", "outputs after reset", upd_slope, 0);

    request(2'd1, 64,   16'h7735, "R2", 1'b0);  // class B, lower bound, lastA = 0
    request(2'd0, 1522, 16'h7735, "R3", 1'b0);  // class A, upper bound
    request(2'd0, 100,  16'h7735, "R4", 1'b1);  // class A, poke while busy (R9)
    request(2'd1, 1000, 16'h7735, "R5", 1'b0);  // class B uses last A size (R6)
    request(2'd0, 63,   16'h7735, "R1", 1'b0);  // below range
    request(2'd0, 1523, 16'h7735, "R1", 1'b0);  // above range
    request(2'd1, 500,  16'h7735, "R6", 1'b0);  // totals untouched by rejects
    request(2'd2, 500,  16'h7735, "R7", 1'b0);  // invalid class
    request(2'd3, 500,  16'h7735, "R7", 1'b0);
    request(2'd1, 500,  1000,     "R10", 1'b0); // rate below class-A total
    request(2'd0, 500,  0,        "R10", 1'b0); // zero rate for class A
    request(2'd0, 200,  16'h4000, "R4", 1'b0);  // other rate
    request(2'd1, 1522, 16'h4000, "R5", 1'b0);  // B after new A size (R6)
    request(2'd1, 64,   16'hFFFF, "R2", 1'b0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule